// File: doc/BRIEF.md
# Clock Group Generation Controller

This block generates the clock enables for one group of on-chip functions. It picks a base clock from a set of independent source clocks. Changing the pick goes through a handshake, so the base clock never shows a shortened high or low phase. Several fractional dividers run from the base clock at the same time. Each divider produces a single-cycle enable pulse at a programmable rate of N/M of the base clock.

Every function in the group selects one of these divider pulses and receives it as its own clock enable. The enable can be switched off by a software bit. It can also follow an external event line, so the function clock turns on and off automatically.

Configuration uses a simple write port on its own configuration clock. Word address 0 selects the source. The next NDIV addresses hold the divider ratios. The NFUNC addresses after those hold the function settings. Addresses and field positions below assume the default parameters: 3 sources, 3 dividers, 4 functions and 8-bit ratio fields.

Top module: `clkgrp_ctrl`

## Requirements
- R1: Switching the source never produces a base clock high or low phase shorter than the shorter half period of the old and new sources, and at no time is more than one source gated onto the base clock.
- R2: Writing value s to address 0 selects source s when s < NSRC, and the base clock then runs at that source's period. A value of NSRC or more is ignored and the current source stays selected.
- R3: Divider d is written at address 1+d, with N in data[7:0] and M in data[15:8]. With N ≤ M held steady, any window of k·M base cycles contains exactly k·N enable pulses.
- R4: N equal to M gives a pulse on every base cycle. N equal to 0 gives no pulses at all.
- R5: A new N/M takes effect only when the divider's accumulator wraps, so the current period always finishes at the old rate. A stopped divider (N = 0) takes new values on the next base cycle.
- R6: Function f is written at address NDIV+1+f (4 to 7). Bits [1:0] select the divider, bit 2 is the software enable, and bit 3 selects automatic mode. fn_ce[f] is the selected divider's pulse, registered one base cycle later, while the function runs.
- R7: In manual mode (bit 3 clear), a software enable of 0 holds fn_ce[f] low.
- R8: In automatic mode, fn_ce[f] runs while ev_in[f] is high and stays low while it is low; ev_in[f] passes through a two-flop synchronizer first. The software enable bit has no effect in this mode.
- R9: A divider select of NDIV or more gives the function no enable pulses.
- R10: After reset, source 0 is selected, every divider passes the base clock through (N = M = 1), and every function is enabled in manual mode on divider 0. Every fn_ce is therefore high on every base cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration write clock |
| rst | input | 1 | Synchronous active-high reset, held across several cycles of every clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register word address |
| wr_data | input | 2·W (16) | Register write data |
| src_clk | input | NSRC (3) | Candidate source clocks |
| ev_in | input | NFUNC (4) | Event lines for automatic gating, one per function |
| base_clk | output | 1 | Glitch-free selected base clock |
| fn_ce | output | NFUNC (4) | Registered clock enable for each function, in the base clock domain |

## Verification
The hardest condition to reach from the ports is a divider rewrite that lands in the middle of a period. Only this case separates "load at wrap" from "load at once". To reach it, the stimulus first sets a slow 1/8 ratio. It waits until an enable pulse is seen, which means the accumulator has just wrapped. It then writes a fast 1/2 ratio right away and counts the next three base cycles, which must stay silent. Glitch freedom is observed by a monitor that records the shortest high and low phase of the base clock across every source switch.

// File: rtl/clkgrp_pkg.sv
package clkgrp_pkg;

  // Kinds of register word the write port can address
  typedef enum logic [1:0] {
    RK_SRC  = 2'd0,
    RK_DIV  = 2'd1,
    RK_FN   = 2'd2,
    RK_NONE = 2'd3
  } reg_kind_e;

  // Address map: word 0 = source, then one word per divider, then one per function
  function automatic reg_kind_e reg_kind(input int unsigned addr,
                                         input int unsigned ndiv,
                                         input int unsigned nfunc);
    if (addr == 0)                 return RK_SRC;
    else if (addr <= ndiv)         return RK_DIV;
    else if (addr <= ndiv + nfunc) return RK_FN;
    else                           return RK_NONE;
  endfunction

endpackage

// File: rtl/clkgrp_regs.sv
module clkgrp_regs
  import clkgrp_pkg::*;
#(
  parameter int NSRC  = 3,
  parameter int NDIV  = 3,
  parameter int NFUNC = 4,
  parameter int W     = 8,
  parameter int AW    = 4,
  parameter int DW    = 16,
  parameter int SSW   = 2,
  parameter int DSW   = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [DW-1:0]               wr_data,
  output logic [SSW-1:0]              src_sel,
  output logic [NDIV-1:0][W-1:0]      div_n,
  output logic [NDIV-1:0][W-1:0]      div_m,
  output logic [NFUNC-1:0][DSW-1:0]   fn_dsel,
  output logic [NFUNC-1:0]            fn_sw_en,
  output logic [NFUNC-1:0]            fn_auto
);

  reg_kind_e   kind;
  int unsigned idx_div;
  int unsigned idx_fn;

  always_comb begin
    kind    = reg_kind(32'(wr_addr), NDIV, NFUNC);
    idx_div = 32'(wr_addr) - 1;
    idx_fn  = 32'(wr_addr) - 1 - NDIV;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_sel <= '0;
      for (int d = 0; d < NDIV; d++) begin
        div_n[d] <= W'(1);
        div_m[d] <= W'(1);
      end
      for (int f = 0; f < NFUNC; f++) begin
        fn_dsel[f]  <= '0;
        fn_sw_en[f] <= 1'b1;
        fn_auto[f]  <= 1'b0;
      end
    end else if (wr_en) begin
      case (kind)
        RK_SRC: begin
          if (wr_data < DW'(NSRC)) src_sel <= wr_data[SSW-1:0];
        end
        RK_DIV: begin
          for (int d = 0; d < NDIV; d++) begin
            if (idx_div == d) begin
              div_n[d] <= wr_data[W-1:0];
              div_m[d] <= wr_data[2*W-1:W];
            end
          end
        end
        RK_FN: begin
          for (int f = 0; f < NFUNC; f++) begin
            if (idx_fn == f) begin
              fn_dsel[f]  <= wr_data[DSW-1:0];
              fn_sw_en[f] <= wr_data[DSW];
              fn_auto[f]  <= wr_data[DSW+1];
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/clkgrp_srcsel.sv
module clkgrp_srcsel #(
  parameter int NSRC = 3,
  parameter int SSW  = 2
) (
  input  logic [NSRC-1:0] src_clk,
  input  logic            rst,
  input  logic [SSW-1:0]  sel,
  output logic [NSRC-1:0] gate,
  output logic            base_clk
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic req;
    logic s1_q;
    logic g_q;

    // Ask for this source only when selected and every other gate is closed
    assign req = (sel == SSW'(i)) && ((gate & ~(NSRC'(1) << i)) == '0);

    always_ff @(posedge src_clk[i]) begin
      if (rst) s1_q <= (i == 0);
      else     s1_q <= req;
    end

    // Gate changes only while this source is low
    always_ff @(negedge src_clk[i]) begin
      if (rst) g_q <= (i == 0);
      else     g_q <= s1_q;
    end

    assign gate[i] = g_q;
  end

  assign base_clk = |(src_clk & gate);

endmodule

// File: rtl/clkgrp_frac_div.sv
module clkgrp_frac_div #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cfg_n,
  input  logic [W-1:0] cfg_m,
  output logic         pulse,
  output logic [W-1:0] n_act,
  output logic [W-1:0] m_act,
  output logic [W-1:0] acc
);

  logic [W:0] sum;
  logic       wrap;
  logic       stopped;
  logic       changed;

  always_comb begin
    sum     = {1'b0, acc} + {1'b0, n_act};
    wrap    = (sum >= {1'b0, m_act}) && (n_act != '0);
    stopped = (n_act == '0);
    changed = (cfg_n != n_act) || (cfg_m != m_act);
    pulse   = wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      n_act <= W'(1);
      m_act <= W'(1);
    end else if (wrap || stopped) begin
      n_act <= cfg_n;
      m_act <= cfg_m;
      if (changed || stopped) acc <= '0;
      else                    acc <= W'(sum - {1'b0, m_act});
    end else begin
      acc <= W'(sum);
    end
  end

endmodule

// File: rtl/clkgrp_fn_gate.sv
module clkgrp_fn_gate #(
  parameter int NDIV = 3,
  parameter int DSW  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NDIV-1:0] pulses,
  input  logic [DSW-1:0]  dsel,
  input  logic            sw_en,
  input  logic            auto_mode,
  input  logic            ev_in,
  output logic            ce
);

  logic ev_s1, ev_s2;
  logic sel_pulse;
  logic run;

  always_comb begin
    sel_pulse = (32'(dsel) < NDIV) ? pulses[dsel] : 1'b0;
    run       = auto_mode ? ev_s2 : sw_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_s1 <= 1'b0;
      ev_s2 <= 1'b0;
      ce    <= 1'b0;
    end else begin
      ev_s1 <= ev_in;
      ev_s2 <= ev_s1;
      ce    <= sel_pulse & run;
    end
  end

endmodule

// File: rtl/clkgrp_ctrl.sv
module clkgrp_ctrl #(
  parameter int NSRC  = 3,
  parameter int NDIV  = 3,
  parameter int NFUNC = 4,
  parameter int W     = 8,
  parameter int AW    = 4
) (
  input  logic               cfg_clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [2*W-1:0]     wr_data,
  input  logic [NSRC-1:0]    src_clk,
  input  logic [NFUNC-1:0]   ev_in,
  output logic               base_clk,
  output logic [NFUNC-1:0]   fn_ce
);

  localparam int DW  = 2 * W;
  localparam int SSW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int DSW = (NDIV > 1) ? $clog2(NDIV) : 1;

  logic [SSW-1:0]             src_sel;
  logic [NSRC-1:0]            src_gate;
  logic [NDIV-1:0][W-1:0]     div_n_cfg, div_m_cfg;
  logic [NDIV-1:0][W-1:0]     div_n_act, div_m_act, div_acc;
  logic [NDIV-1:0]            div_pulse;
  logic [NFUNC-1:0][DSW-1:0]  fn_dsel;
  logic [NFUNC-1:0]           fn_sw_en, fn_auto;

  clkgrp_regs #(
    .NSRC(NSRC), .NDIV(NDIV), .NFUNC(NFUNC), .W(W),
    .AW(AW), .DW(DW), .SSW(SSW), .DSW(DSW)
  ) u_regs (
    .clk      (cfg_clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .src_sel  (src_sel),
    .div_n    (div_n_cfg),
    .div_m    (div_m_cfg),
    .fn_dsel  (fn_dsel),
    .fn_sw_en (fn_sw_en),
    .fn_auto  (fn_auto)
  );

  clkgrp_srcsel #(.NSRC(NSRC), .SSW(SSW)) u_srcsel (
    .src_clk  (src_clk),
    .rst      (rst),
    .sel      (src_sel),
    .gate     (src_gate),
    .base_clk (base_clk)
  );

  for (genvar d = 0; d < NDIV; d++) begin : g_div
    clkgrp_frac_div #(.W(W)) u_div (
      .clk   (base_clk),
      .rst   (rst),
      .cfg_n (div_n_cfg[d]),
      .cfg_m (div_m_cfg[d]),
      .pulse (div_pulse[d]),
      .n_act (div_n_act[d]),
      .m_act (div_m_act[d]),
      .acc   (div_acc[d])
    );
  end

  for (genvar f = 0; f < NFUNC; f++) begin : g_fn
    clkgrp_fn_gate #(.NDIV(NDIV), .DSW(DSW)) u_gate (
      .clk       (base_clk),
      .rst       (rst),
      .pulses    (div_pulse),
      .dsel      (fn_dsel[f]),
      .sw_en     (fn_sw_en[f]),
      .auto_mode (fn_auto[f]),
      .ev_in     (ev_in[f]),
      .ce        (fn_ce[f])
    );
  end

endmodule

// File: rtl/clkgrp_ctrl_chk.sv
module clkgrp_ctrl_chk #(
  parameter int NSRC  = 3,
  parameter int NDIV  = 3,
  parameter int NFUNC = 4,
  parameter int W     = 8,
  parameter int DSW   = 2
) (
  input  logic                       cfg_clk,
  input  logic                       base_clk,
  input  logic                       rst,
  input  logic [NSRC-1:0]            src_gate,
  input  logic [NDIV-1:0]            div_pulse,
  input  logic [NDIV-1:0][W-1:0]     div_n_act,
  input  logic [NDIV-1:0][W-1:0]     div_m_act,
  input  logic [NDIV-1:0][W-1:0]     div_acc,
  input  logic [NFUNC-1:0]           fn_ce,
  input  logic [NFUNC-1:0][DSW-1:0]  fn_dsel
);

  // R1: never two sources on the base clock together
  p_gate_onehot0_r1: assert property (@(posedge cfg_clk) disable iff (rst)
    $onehot0(src_gate))
    else $error("p_gate_onehot0_r1: gates %b", src_gate);

  for (genvar d = 0; d < NDIV; d++) begin : g_dchk
    // R3: remainder stays below the modulus
    p_acc_bound_r3: assert property (@(posedge base_clk) disable iff (rst)
      (div_m_act[d] != '0) |-> (div_acc[d] < div_m_act[d]))
      else $error("p_acc_bound_r3: divider %0d", d);

    // R4: pass-through pulses every cycle
    p_pass_r4: assert property (@(posedge base_clk) disable iff (rst)
      ((div_m_act[d] != '0) && (div_n_act[d] == div_m_act[d])) |-> div_pulse[d])
      else $error("p_pass_r4: divider %0d", d);

    // R4: stopped divider stays silent
    p_stop_r4: assert property (@(posedge base_clk) disable iff (rst)
      (div_n_act[d] == '0) |-> !div_pulse[d])
      else $error("p_stop_r4: divider %0d", d);

    // R5: ratio held unless the accumulator wrapped
    p_hold_r5: assert property (@(posedge base_clk) disable iff (rst)
      (!div_pulse[d] && (div_n_act[d] != '0)) |=>
        ($stable(div_n_act[d]) && $stable(div_m_act[d])))
      else $error("p_hold_r5: divider %0d", d);
  end

  for (genvar f = 0; f < NFUNC; f++) begin : g_fchk
    logic sel_pulse;
    assign sel_pulse = (32'(fn_dsel[f]) < NDIV) ? div_pulse[fn_dsel[f]] : 1'b0;

    // R6: an enable follows a pulse of the chosen divider one cycle earlier
    p_ce_src_r6: assert property (@(posedge base_clk) disable iff (rst)
      fn_ce[f] |-> $past(sel_pulse))
      else $error("p_ce_src_r6: function %0d", f);
  end

endmodule

bind clkgrp_ctrl clkgrp_ctrl_chk #(
  .NSRC(NSRC), .NDIV(NDIV), .NFUNC(NFUNC), .W(W), .DSW(DSW)
) i_clkgrp_chk (
  .cfg_clk   (cfg_clk),
  .base_clk  (base_clk),
  .rst       (rst),
  .src_gate  (src_gate),
  .div_pulse (div_pulse),
  .div_n_act (div_n_act),
  .div_m_act (div_m_act),
  .div_acc   (div_acc),
  .fn_ce     (fn_ce),
  .fn_dsel   (fn_dsel)
);

// File: tb/test_clkgrp_ctrl.sv
`timescale 1ns/1ps
module test_clkgrp_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 3;
  localparam int NF = 4;
  localparam int SRC1_HALF = 7;
  localparam int SRC2_HALF = 3;
  localparam int NVEC = 8;
  // {N, M, expected pulses in a window of 4*M base cycles}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd1, 8'd1, 8'd4},  {8'd1, 8'd2, 8'd4},  {8'd3, 8'd4, 8'd12}, {8'd2, 8'd3, 8'd8},
    {8'd5, 8'd7, 8'd20}, {8'd0, 8'd5, 8'd0},  {8'd4, 8'd6, 8'd16}, {8'd8, 8'd8, 8'd32}
  };

  logic            cfg_clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [3:0]      wr_addr = '0;
  logic [15:0]     wr_data = '0;
  logic [NS-1:0]   src_clk = '0;
  logic [NF-1:0]   ev_in = '0;
  logic            base_clk;
  logic [NF-1:0]   fn_ce;

  int  n_checks = 0;
  int  n_fail = 0;
  int  cnt [NF];
  bit  done = 1'b0;
  bit  mon_on = 1'b0;
  realtime last_t = 0.0;
  real min_hi = 1.0e9;
  real min_lo = 1.0e9;

  clkgrp_ctrl i_clkgrp_ctrl (
    .cfg_clk  (cfg_clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .src_clk  (src_clk),
    .ev_in    (ev_in),
    .base_clk (base_clk),
    .fn_ce    (fn_ce)
  );

  initial begin #2; forever #(CLK_PERIOD/2) cfg_clk = ~cfg_clk; end
  initial forever #(CLK_PERIOD/2) src_clk[0] = ~src_clk[0];
  initial forever #(SRC1_HALF)    src_clk[1] = ~src_clk[1];
  initial forever #(SRC2_HALF)    src_clk[2] = ~src_clk[2];

  // Shortest high and low phase of the base clock
  always @(base_clk) begin
    if (mon_on) begin
      if (base_clk === 1'b0 && ($realtime - last_t) < min_hi) min_hi = $realtime - last_t;
      if (base_clk === 1'b1 && ($realtime - last_t) < min_lo) min_lo = $realtime - last_t;
    end
    last_t = $realtime;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge cfg_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge cfg_clk);
    wr_en = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge base_clk);
  endtask

  task automatic count_all(input int ncyc);
    for (int f = 0; f < NF; f++) cnt[f] = 0;
    repeat (ncyc) begin
      @(negedge base_clk);
      for (int f = 0; f < NF; f++) if (fn_ce[f]) cnt[f]++;
    end
  endtask

  task automatic measure(output int per);
    realtime t0;
    @(posedge base_clk); t0 = $realtime;
    @(posedge base_clk); per = int'($realtime - t0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int per;
    repeat (12) @(negedge cfg_clk);
    rst = 1'b0;
    mon_on = 1'b1;

    // R10: reset state
    settle(4);
    measure(per);
    chk("R10 base period on source 0", per, CLK_PERIOD);
    count_all(8);
    for (int f = 0; f < NF; f++) chk("R10 pass-through enable", cnt[f], 8);

    // R3 / R4: ratio table on divider 0, seen on function 0
    for (int v = 0; v < NVEC; v++) begin
      wr(4'd1, {VEC[v][15:8], VEC[v][23:16]});
      settle(24);
      count_all(4 * int'(VEC[v][15:8]));
      chk("R3/R4 ratio vector", cnt[0], int'(VEC[v][7:0]));
    end

    // R5: rewrite just after a wrap must not shorten the running period
    wr(4'd1, {8'd8, 8'd1});
    settle(24);
    do @(negedge base_clk); while (!fn_ce[0]);
    wr(4'd1, {8'd2, 8'd1});
    count_all(3);
    chk("R5 no change mid-period", cnt[0], 0);
    settle(20);
    count_all(8);
    chk("R5 new ratio after wrap", cnt[0], 4);

    // R6 / R7: routing and software disable
    wr(4'd1, {8'd1, 8'd1});
    wr(4'd2, {8'd3, 8'd1});
    wr(4'd3, {8'd5, 8'd2});
    wr(4'd5, 16'h0005);   // function 1: divider 1, enabled
    wr(4'd6, 16'h0006);   // function 2: divider 2, enabled
    wr(4'd7, 16'h0000);   // function 3: manual, disabled
    settle(30);
    count_all(30);
    chk("R6 function 0 on divider 0", cnt[0], 30);
    chk("R6 function 1 on divider 1", cnt[1], 10);
    chk("R6 function 2 on divider 2", cnt[2], 12);
    chk("R7 software disable", cnt[3], 0);

    // R8: automatic mode with software enable clear
    wr(4'd7, 16'h0008);
    ev_in[3] = 1'b0;
    settle(10);
    count_all(10);
    chk("R8 event low gates off", cnt[3], 0);
    ev_in[3] = 1'b1;
    settle(10);
    count_all(10);
    chk("R8 event high runs", cnt[3], 10);
    ev_in[3] = 1'b0;

    // R9: divider select out of range
    wr(4'd7, 16'h0007);
    settle(10);
    count_all(10);
    chk("R9 invalid divider select", cnt[3], 0);

    // R1 / R2: source switching
    wr(4'd0, 16'd1);
    repeat (20) @(negedge cfg_clk);
    measure(per);
    chk("R2 source 1 period", per, 2 * SRC1_HALF);
    wr(4'd0, 16'd2);
    repeat (20) @(negedge cfg_clk);
    measure(per);
    chk("R2 source 2 period", per, 2 * SRC2_HALF);
    count_all(10);
    chk("R2 dividers follow new source", cnt[0], 10);
    wr(4'd0, 16'd5);
    repeat (20) @(negedge cfg_clk);
    measure(per);
    chk("R2 out-of-range select ignored", per, 2 * SRC2_HALF);
    wr(4'd0, 16'd0);
    repeat (20) @(negedge cfg_clk);
    measure(per);
    chk("R1 back on source 0", per, CLK_PERIOD);
    chk("R1 shortest high phase", (min_hi >= 2.999) ? 1 : 0, 1);
    chk("R1 shortest low phase",  (min_lo >= 2.999) ? 1 : 0, 1);

    done = 1'b1;
    finish_run();
  end

endmodule